// File: doc/BRIEF.md
# SPI-to-I2C Transaction Sequencer

This block is the control core of a bridge that lets a host on an SPI bus run transfers on an I2C bus. It sits between an SPI slave receiver and an I2C master bit engine. It watches the receiver's busy/ready handshake and captures each 32-bit command word as it arrives. When the word's enable flag is set, it issues a single request to the I2C engine. The request carries a 7-bit target address, a direction bit and one write byte.

When the engine reports completion, the sequencer waits until the SPI side is idle. It then posts a result word into a return register that the SPI slave shifts back to the host on the next exchange. A command whose enable flag is clear is consumed and dropped, and the I2C engine is never touched. The SPI shifter and the I2C bit engine are separate blocks, reached through plain level and pulse handshakes.

Top module: `xfer_bridge_seq`

## Requirements
- R1: While `spi_busy` is high or `spi_ready` is low, the sequencer stays waiting: no word is captured, no start pulse is issued and the result register keeps its value.
- R2: On a clock edge where the sequencer is waiting, `spi_busy` is low and `spi_ready` is high, `spi_word` is captured.
- R3: Command word fields: bits [6:0] are the target address, bit 7 is the direction (0 write, 1 read), bits [15:8] are the write byte, and bit 24 is the enable flag. All other bits are ignored.
- R4: A captured word with bit 24 clear returns the sequencer to waiting, and no start pulse is issued.
- R5: A captured word with bit 24 set produces exactly one `i2c_go` pulse, one cycle wide, high in the cycle after the second rising edge counted from the capture edge. While it is high, `i2c_addr`, `i2c_read` and `i2c_wbyte` show the decoded fields.
- R6: After the start pulse, the sequencer waits for `i2c_done`. A `i2c_done` pulse at any other time has no effect.
- R7: The result is posted only once `i2c_done` has been seen and `spi_busy` is low. While `spi_busy` stays high, posting is held back.
- R8: Result register layout: bits [7:0] hold the read byte (zero after a write), bit 8 holds the acknowledge error, bit 9 is the valid flag, and the upper bits are zero. The whole register clears to zero on the edge that captures the next command.
- R9: From capture until the return to waiting, further SPI handshakes are not captured, and the decoded fields stay unchanged.
- R10: A synchronous active-high `rst` returns the sequencer to waiting, clears the captured word and the result register, and holds `i2c_go` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_busy | input | 1 | SPI receiver is shifting |
| spi_ready | input | 1 | SPI receiver holds a complete word |
| spi_word | input | 32 | Word from the SPI receiver |
| i2c_go | output | 1 | One-cycle start request to the I2C engine |
| i2c_addr | output | 7 | Target address |
| i2c_read | output | 1 | Direction, 1 = read |
| i2c_wbyte | output | 8 | Byte to write |
| i2c_done | input | 1 | Engine completion pulse |
| i2c_nack | input | 1 | Engine saw no acknowledge |
| i2c_rbyte | input | 8 | Byte read by the engine |
| ret_word | output | 32 | Result register returned over SPI |

## Verification
The capture handshake is tried with four input patterns: busy and ready both high, both low, ready held high during an active transfer, and the true capture condition. This shows that only the busy-low, ready-high combination advances the sequencer, and only while it is waiting. Write and read commands use different addresses, bytes, acknowledge outcomes and reserved-bit patterns, which separates field decode from reserved-bit leakage and shows read bytes being masked after writes. A command with the enable flag clear, a completion pulse that arrives while idle, and completion with the SPI side held busy each isolate one gating condition. A reset in mid-transfer checks that all state clears.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_DECODE = 2'd1,
      ST_XFER = 2'd2,
      ST_POST = 2'd3
   } seq_state_t;
endpackage

// File: rtl/bridge_cmd_reg.sv
module bridge_cmd_reg #(
   parameter int CMD_W  = 32,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int EN_BIT = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CMD_W-1:0]  word_in,
   output logic [ADDR_W-1:0] addr,
   output logic              rd,
   output logic [DATA_W-1:0] wbyte,
   output logic              enable
);
   localparam int RD_BIT = ADDR_W;
   localparam int WB_LO  = ADDR_W + 1;
   localparam int WB_HI  = WB_LO + DATA_W - 1;

   initial begin
      assert (WB_HI < EN_BIT) else $fatal(1, "enable bit overlaps data field");
      assert (EN_BIT < CMD_W) else $fatal(1, "enable bit outside word");
   end

   logic [CMD_W-1:0] held;

   always_ff @(posedge clk) begin
      if (rst)       held <= '0;
      else if (load) held <= word_in;
   end

   assign addr   = held[ADDR_W-1:0];
   assign rd     = held[RD_BIT];
   assign wbyte  = held[WB_HI:WB_LO];
   assign enable = held[EN_BIT];
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
   import bridge_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic spi_busy,
   input  logic spi_ready,
   input  logic cmd_en,
   input  logic done,
   output logic load,
   output logic capture,
   output logic commit,
   output logic go,
   output logic waiting
);
   seq_state_t st;

   always_comb begin
      load    = (st == ST_WAIT) && !spi_busy && spi_ready;
      capture = (st == ST_XFER) && done;
      commit  = (st == ST_POST) && !spi_busy;
      waiting = (st == ST_WAIT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= ST_WAIT;
         go <= 1'b0;
      end else begin
         go <= (st == ST_DECODE) && cmd_en;
         unique case (st)
            ST_WAIT:   if (load) st <= ST_DECODE;
            ST_DECODE: st <= cmd_en ? ST_XFER : ST_WAIT;
            ST_XFER:   if (capture) st <= ST_POST;
            ST_POST:   if (commit) st <= ST_WAIT;
            default:   st <= ST_WAIT;
         endcase
      end
   end

   a_r1_hold_wait: assert property (@(posedge clk) disable iff (rst)
      (st == ST_WAIT && (spi_busy || !spi_ready)) |=> (st == ST_WAIT));
   a_r4_skip_disabled: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DECODE && !cmd_en) |=> (st == ST_WAIT && !go));
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
      go |=> !go);
   a_r5_pulse_in_xfer: assert property (@(posedge clk) disable iff (rst)
      go |-> (st == ST_XFER));
   a_r6_wait_done: assert property (@(posedge clk) disable iff (rst)
      (st == ST_XFER && !done) |=> (st == ST_XFER));
   a_r10_reset: assert property (@(posedge clk)
      rst |=> (st == ST_WAIT && !go));
endmodule

// File: rtl/bridge_result.sv
module bridge_result #(
   parameter int DATA_W = 8,
   parameter int TX_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              capture,
   input  logic              commit,
   input  logic              rd,
   input  logic              nack,
   input  logic [DATA_W-1:0] rbyte,
   output logic [TX_W-1:0]   tx_word
);
   localparam int ACK_BIT = DATA_W;
   localparam int VLD_BIT = DATA_W + 1;

   initial begin
      assert (TX_W > VLD_BIT) else $fatal(1, "return word too narrow");
   end

   logic [DATA_W-1:0] pend_byte;
   logic              pend_nack;
   logic [VLD_BIT:0]  low_bits;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_byte <= '0;
         pend_nack <= 1'b0;
      end else if (capture) begin
         pend_byte <= rd ? rbyte : '0;
         pend_nack <= nack;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear) low_bits <= '0;
      else if (commit)  low_bits <= {1'b1, pend_nack, pend_byte};
   end

   generate
      if (TX_W > VLD_BIT + 1) begin : g_pad
         assign tx_word = {{(TX_W-VLD_BIT-1){1'b0}}, low_bits};
      end else begin : g_exact
         assign tx_word = low_bits;
      end
   endgenerate

   a_r8_clear_on_load: assert property (@(posedge clk) disable iff (rst)
      clear |=> (tx_word == '0));
   a_r8_valid_needs_commit: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_word[VLD_BIT]) |-> $past(commit));
endmodule

// File: rtl/xfer_bridge_seq.sv
module xfer_bridge_seq #(
   parameter int CMD_W  = 32,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int EN_BIT = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              spi_busy,
   input  logic              spi_ready,
   input  logic [CMD_W-1:0]  spi_word,
   output logic              i2c_go,
   output logic [ADDR_W-1:0] i2c_addr,
   output logic              i2c_read,
   output logic [DATA_W-1:0] i2c_wbyte,
   input  logic              i2c_done,
   input  logic              i2c_nack,
   input  logic [DATA_W-1:0] i2c_rbyte,
   output logic [CMD_W-1:0]  ret_word
);
   localparam int VLD_BIT = DATA_W + 1;

   logic load, capture, commit, cmd_en, waiting;

   bridge_cmd_reg #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_cmd (
      .clk(clk), .rst(rst), .load(load), .word_in(spi_word),
      .addr(i2c_addr), .rd(i2c_read), .wbyte(i2c_wbyte), .enable(cmd_en));

   bridge_seq u_seq (
      .clk(clk), .rst(rst), .spi_busy(spi_busy), .spi_ready(spi_ready),
      .cmd_en(cmd_en), .done(i2c_done), .load(load), .capture(capture),
      .commit(commit), .go(i2c_go), .waiting(waiting));

   bridge_result #(.DATA_W(DATA_W), .TX_W(CMD_W)) u_res (
      .clk(clk), .rst(rst), .clear(load), .capture(capture), .commit(commit),
      .rd(i2c_read), .nack(i2c_nack), .rbyte(i2c_rbyte), .tx_word(ret_word));

   a_r7_post_when_idle: assert property (@(posedge clk) disable iff (rst)
      $rose(ret_word[VLD_BIT]) |-> $past(!spi_busy));
   a_r9_fields_frozen: assert property (@(posedge clk) disable iff (rst)
      !waiting |=> ($stable(i2c_addr) && $stable(i2c_read) && $stable(i2c_wbyte)));
   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (ret_word == '0 && i2c_addr == '0));
endmodule

// File: tb/sim_xfer_bridge_seq.sv
module sim_xfer_bridge_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        spi_busy = 1'b0;
   logic        spi_ready = 1'b0;
   logic [31:0] spi_word = '0;
   logic        i2c_go;
   logic [6:0]  i2c_addr;
   logic        i2c_read;
   logic [7:0]  i2c_wbyte;
   logic        i2c_done = 1'b0;
   logic        i2c_nack = 1'b0;
   logic [7:0]  i2c_rbyte = '0;
   logic [31:0] ret_word;

   int checks = 0;
   int errors = 0;
   int starts = 0;

   localparam logic [31:0] EN = 32'h0100_0000;

   always #2.5 clk = ~clk;

   xfer_bridge_seq u0 (
      .clk(clk), .rst(rst), .spi_busy(spi_busy), .spi_ready(spi_ready),
      .spi_word(spi_word), .i2c_go(i2c_go), .i2c_addr(i2c_addr),
      .i2c_read(i2c_read), .i2c_wbyte(i2c_wbyte), .i2c_done(i2c_done),
      .i2c_nack(i2c_nack), .i2c_rbyte(i2c_rbyte), .ret_word(ret_word));

   always @(posedge clk) if (i2c_go) starts++;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      spi_word = w; spi_ready = 1'b1; spi_busy = 1'b0;
      @(negedge clk);
      spi_ready = 1'b0;
   endtask

   task automatic finish_xfer(input logic [7:0] rb, input logic nk);
      @(negedge clk);
      i2c_done = 1'b1; i2c_rbyte = rb; i2c_nack = nk;
      @(negedge clk);
      i2c_done = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      cycles(3);
      rst = 1'b0;
      chk(ret_word == 32'h0, "R10 reset ret_word", ret_word, 32'h0);
      chk(i2c_go == 1'b0, "R10 reset go", {31'h0, i2c_go}, 32'h0);
   endtask

   task automatic t_idle();
      int s0 = starts;
      @(negedge clk);
      spi_word = EN | 32'h55; spi_busy = 1'b1; spi_ready = 1'b1;
      cycles(5);
      spi_busy = 1'b0; spi_ready = 1'b0;
      cycles(5);
      chk(starts == s0, "R1 no start while busy/not ready", starts, s0);
      chk(i2c_addr == 7'h0, "R1 word not captured", {25'h0, i2c_addr}, 32'h0);
      @(negedge clk); i2c_done = 1'b1;
      @(negedge clk); i2c_done = 1'b0;
      cycles(3);
      chk(ret_word == 32'h0, "R6 done while idle ignored", ret_word, 32'h0);
   endtask

   task automatic t_write();
      int s0 = starts;
      send(EN | 32'h0000_3C52);
      chk(i2c_addr == 7'h52, "R2 address captured", {25'h0, i2c_addr}, 32'h52);
      @(negedge clk);
      chk(i2c_go == 1'b1, "R5 go after decode", {31'h0, i2c_go}, 32'h1);
      chk(i2c_read == 1'b0 && i2c_wbyte == 8'h3C, "R3 write fields",
          {23'h0, i2c_read, i2c_wbyte}, 32'h3C);
      @(negedge clk);
      chk(i2c_go == 1'b0, "R5 go one cycle", {31'h0, i2c_go}, 32'h0);
      cycles(8);
      chk(ret_word == 32'h0, "R6 no result before done", ret_word, 32'h0);
      finish_xfer(8'hEE, 1'b0);
      chk(ret_word == 32'h200, "R8 write result masks read byte", ret_word, 32'h200);
      chk(starts == s0 + 1, "R5 exactly one start", starts, s0 + 1);
   endtask

   task automatic t_read();
      send(32'hFEFF_0091 | EN);
      chk(i2c_addr == 7'h11 && i2c_read == 1'b1, "R3 read fields, reserved ignored",
          {24'h0, i2c_read, i2c_addr}, 32'h91);
      chk(ret_word == 32'h0, "R8 cleared on capture", ret_word, 32'h0);
      cycles(3);
      finish_xfer(8'hA5, 1'b1);
      chk(ret_word == 32'h3A5, "R8 read result with nack", ret_word, 32'h3A5);
   endtask

   task automatic t_disabled();
      int s0 = starts;
      send(32'h0000_1234);
      chk(ret_word == 32'h0, "R8 clear by disabled command", ret_word, 32'h0);
      cycles(6);
      chk(starts == s0, "R4 disabled command no start", starts, s0);
      send(EN | 32'h0000_0009);
      cycles(2);
      chk(starts == s0 + 1, "R4 returned to waiting", starts, s0 + 1);
      finish_xfer(8'h00, 1'b0);
   endtask

   task automatic t_busy_hold();
      send(EN | 32'h0000_80A0);
      @(negedge clk); spi_busy = 1'b1;
      finish_xfer(8'h5A, 1'b0);
      cycles(4);
      chk(ret_word[9] == 1'b0, "R7 held while spi busy", ret_word, 32'h0);
      spi_busy = 1'b0;
      @(negedge clk);
      chk(ret_word == 32'h25A, "R7 posted after busy drops", ret_word, 32'h25A);
   endtask

   task automatic t_no_relatch();
      int s0 = starts;
      send(EN | 32'h0000_0022);
      cycles(2);
      @(negedge clk);
      spi_word = EN | 32'h0000_7733; spi_ready = 1'b1; spi_busy = 1'b0;
      @(negedge clk); spi_ready = 1'b0;
      cycles(2);
      chk(i2c_addr == 7'h22, "R9 no capture during transfer", {25'h0, i2c_addr}, 32'h22);
      chk(starts == s0 + 1, "R9 no extra start", starts, s0 + 1);
      finish_xfer(8'h00, 1'b0);
      chk(ret_word == 32'h200, "R9 original transfer completes", ret_word, 32'h200);
   endtask

   task automatic t_mid_reset();
      send(EN | 32'h0000_0144);
      cycles(3);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(ret_word == 32'h0 && i2c_addr == 7'h0 && i2c_go == 1'b0,
          "R10 mid-transfer reset", {ret_word[23:0], 1'b0, i2c_addr}, 32'h0);
      finish_xfer(8'h99, 1'b1);
      chk(ret_word == 32'h0, "R10 sequencer back to waiting", ret_word, 32'h0);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_write();
      t_read();
      t_disabled();
      t_busy_hold();
      t_no_relatch();
      t_mid_reset();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule